// File: doc/BRIEF.md
# Paged Switch Register Access Bridge

The bridge serves a controller that needs to read or write the 32-bit registers of an Ethernet switch. The switch can only be reached through a management port that moves 16 bits per transaction. One upstream request starts a chain of three downstream transactions. The first writes a page number into a fixed page-select location. The other two carry the two 16-bit halves of the register. The bridge takes the downstream PHY and register addresses from bit slices of the switch register address.

Two switch variants are supported through the `VARIANT` parameter.

- They use different page-select locations.
- Variant 0 has one register whose halves must be written lower half first. Every other write sends the upper half first.

Each downstream transaction is guarded by its own timeout. An error or a timeout on any transaction ends the chain at once, and the bridge reports a status code.

Top module: `swreg_bridge`

## Requirements
- R1: The first downstream transaction of every request is a write of `addr >> 9`, zero-extended to 16 bits, to the page-select location. That location is PHY 0x1F, register 0x10 when `VARIANT` = 0, and PHY 0x18, register 0x00 when `VARIANT` = 1.
- R2: Both half transactions use PHY address `{2'b10, addr[8:6]}`, which equals `((addr >> 6) & 7) | 0x10`.
- R3: A half transaction uses register `{addr[5:2], h}`, where h = 0 for the lower half and h = 1 for the upper half.
- R4: A read fetches the lower half first, then the upper half. On success, `req_rdata` equals `{upper, lower}` while `req_done` is high and afterwards.
- R5: A write sends the upper half (`wdata[31:16]`) first, then the lower half (`wdata[15:0]`). All three transactions of a write have `cmd_write` = 1, and the half transactions of a read have `cmd_write` = 0.
- R6: When `VARIANT` = 0, a write to switch register 0x98 sends the lower half first, then the upper half. Reads of 0x98 keep the normal order. When `VARIANT` = 1, register 0x98 follows the normal rules.
- R7: A transaction completed with `cmd_err` = 1 ends the request. No further transaction is issued, and the status is 2'b01.
- R8: A transaction with no `cmd_done` within `TIMEOUT_CYCLES` cycles ends the request. `cmd_valid` drops and the status is 2'b10.
- R9: `req_done` is high for exactly one cycle. On success, it rises in the cycle after the final `cmd_done` and carries status 2'b00.
- R10: `req_start` is ignored while a request is in progress. It causes no additional transactions and no additional `req_done`.
- R11: After reset, `req_done` = 0, `cmd_valid` = 0, `req_status` = 0 and `req_rdata` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_start | input | 1 | Starts a request when the bridge is idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Switch register address |
| req_wdata | input | 32 | Write data |
| req_done | output | 1 | One-cycle completion pulse |
| req_status | output | 2 | 00 ok, 01 downstream error, 10 timeout |
| req_rdata | output | 32 | Read result |
| cmd_valid | output | 1 | Downstream transaction pending |
| cmd_write | output | 1 | Downstream transaction is a write |
| cmd_phy | output | 5 | Downstream PHY address |
| cmd_reg | output | 5 | Downstream register address |
| cmd_wdata | output | 16 | Downstream write data |
| cmd_done | input | 1 | Downstream transaction complete |
| cmd_err | input | 1 | Downstream error, qualified by cmd_done |
| cmd_rdata | input | 16 | Downstream read data, qualified by cmd_done |

## Verification
Random requests over the whole 10-bit address space with random data and response latency test the address slicing for every page and sub-page. Each downstream read returns a value derived from its own PHY and register addresses, so a swapped or misplaced half shows up in the assembled result.

Directed requests to register 0x98 on both variants separate the reversed write order from the normal one. They also confirm that reads and the other variant are unaffected.

An error injected on each transaction in turn, together with a stalled transaction, confirms that the chain stops at the right point with the right code. A second start pulse during a request must leave the transaction log and the done count unchanged.

// File: rtl/swreg_bridge.sv
module swreg_bridge #(
  parameter int VARIANT        = 0,
  parameter int ADDR_W         = 10,
  parameter int TIMEOUT_CYCLES = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_start,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              req_done,
  output logic [1:0]        req_status,
  output logic [31:0]       req_rdata,
  output logic              cmd_valid,
  output logic              cmd_write,
  output logic [4:0]        cmd_phy,
  output logic [4:0]        cmd_reg,
  output logic [15:0]       cmd_wdata,
  input  logic              cmd_done,
  input  logic              cmd_err,
  input  logic [15:0]       cmd_rdata
);
  localparam int TW = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [4:0] PG_PHY = (VARIANT == 0) ? 5'h1F : 5'h18;
  localparam logic [4:0] PG_REG = (VARIANT == 0) ? 5'h10 : 5'h00;
  localparam logic [1:0] ST_OK = 2'b00, ST_ERR = 2'b01, ST_TMO = 2'b10;

  typedef enum logic [1:0] {S_IDLE, S_PAGE, S_FIRST, S_SECOND} state_t;

  state_t            st;
  logic [ADDR_W-1:0] a_q;
  logic [31:0]       d_q;
  logic              w_q, lo_first;
  logic [TW-1:0]     tcnt;
  logic              cur_high;

  assign cur_high  = (st == S_FIRST) ? !lo_first : lo_first;
  assign cmd_valid = (st != S_IDLE);
  assign cmd_write = (st == S_PAGE) || w_q;
  assign cmd_phy   = (st == S_PAGE) ? PG_PHY : {2'b10, a_q[8:6]};
  assign cmd_reg   = (st == S_PAGE) ? PG_REG : {a_q[5:2], cur_high};
  assign cmd_wdata = (st == S_PAGE) ? 16'(a_q >> 9)
                   : (cur_high ? d_q[31:16] : d_q[15:0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      a_q        <= '0;
      d_q        <= '0;
      w_q        <= 1'b0;
      lo_first   <= 1'b1;
      tcnt       <= '0;
      req_done   <= 1'b0;
      req_status <= ST_OK;
      req_rdata  <= '0;
    end else begin
      req_done <= 1'b0;
      if (st == S_IDLE) begin
        if (req_start) begin
          a_q      <= req_addr;
          d_q      <= req_wdata;
          w_q      <= req_write;
          lo_first <= !req_write ||
                      ((VARIANT == 0) && (req_addr == ADDR_W'(10'h098)));
          tcnt     <= '0;
          st       <= S_PAGE;
        end
      end else if (cmd_done) begin
        tcnt <= '0;
        if (cmd_err) begin
          st         <= S_IDLE;
          req_done   <= 1'b1;
          req_status <= ST_ERR;
        end else begin
          if (st != S_PAGE && !w_q) begin
            if (cur_high) req_rdata[31:16] <= cmd_rdata;
            else          req_rdata[15:0]  <= cmd_rdata;
          end
          case (st)
            S_PAGE:  st <= S_FIRST;
            S_FIRST: st <= S_SECOND;
            default: begin
              st         <= S_IDLE;
              req_done   <= 1'b1;
              req_status <= ST_OK;
            end
          endcase
        end
      end else if (tcnt == TW'(TIMEOUT_CYCLES - 1)) begin
        st         <= S_IDLE;
        req_done   <= 1'b1;
        req_status <= ST_TMO;
      end else begin
        tcnt <= tcnt + 1'b1;
      end
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    req_done |=> !req_done); // R9
  AST_DONE_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (req_done && req_status == ST_OK) |-> $past(cmd_done)); // R9
  AST_PAGE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_valid) |-> (cmd_write && cmd_phy == PG_PHY && cmd_reg == PG_REG)); // R1
  AST_ERR_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_done && cmd_err) |=> (!cmd_valid && req_done && req_status == ST_ERR)); // R7
  AST_CMD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_done) |=> (!cmd_valid || $stable({cmd_write, cmd_phy, cmd_reg, cmd_wdata}))); // R10
  AST_TMO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    tcnt < TW'(TIMEOUT_CYCLES)); // R8
endmodule

// File: tb/sim_swreg_bridge.sv
module sim_resp (
  input  logic        clk,
  input  logic        clr,
  input  logic        cmd_valid,
  input  logic        cmd_write,
  input  logic [4:0]  phy,
  input  logic [4:0]  rg,
  input  logic [15:0] wd,
  input  int          lat,
  input  int          fail_idx,
  input  int          hang_idx,
  output logic        done,
  output logic        err,
  output logic [15:0] rdata
);
  int n, cur, cnt;
  logic busy;
  logic [4:0]  lphy [8];
  logic [4:0]  lreg [8];
  logic        lw   [8];
  logic [15:0] ld   [8];

  always @(posedge clk) begin
    done <= 1'b0;
    err  <= 1'b0;
    if (clr) begin
      n <= 0; busy <= 1'b0; cur <= 0; cnt <= 0; rdata <= '0;
    end else if (!busy) begin
      if (cmd_valid && !done && n < 8) begin
        lphy[n] <= phy; lreg[n] <= rg; lw[n] <= cmd_write; ld[n] <= wd;
        cur <= n; n <= n + 1; busy <= 1'b1; cnt <= lat;
      end
    end else if (cur != hang_idx) begin
      if (cnt == 0) begin
        done  <= 1'b1;
        err   <= (cur == fail_idx);
        busy  <= 1'b0;
        rdata <= {lphy[cur], 1'b0, lreg[cur], 5'h0} ^ 16'h5A5A;
      end else cnt <= cnt - 1;
    end
  end
endmodule

module sim_swreg_bridge;
  localparam int CLK_PERIOD = 10;
  localparam int TMO = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic start0 = 0, start1 = 0, wr = 0, clr = 1;
  logic [9:0]  addr = '0;
  logic [31:0] wdat = '0;
  int lat = 0, fail_idx = -1, hang_idx = -1;

  logic done0, done1, v0, v1, cw0, cw1, ack0, ack1, err0, err1;
  logic [1:0] st0, st1;
  logic [31:0] rd0, rd1;
  logic [4:0] ph0, ph1, rg0, rg1;
  logic [15:0] cd0, cd1, rdd0, rdd1;

  swreg_bridge #(.VARIANT(0), .TIMEOUT_CYCLES(TMO)) u0 (
    .clk, .rst_n, .req_start(start0), .req_write(wr), .req_addr(addr), .req_wdata(wdat),
    .req_done(done0), .req_status(st0), .req_rdata(rd0),
    .cmd_valid(v0), .cmd_write(cw0), .cmd_phy(ph0), .cmd_reg(rg0), .cmd_wdata(cd0),
    .cmd_done(ack0), .cmd_err(err0), .cmd_rdata(rdd0));
  sim_resp r0 (.clk, .clr, .cmd_valid(v0), .cmd_write(cw0), .phy(ph0), .rg(rg0), .wd(cd0),
    .lat, .fail_idx, .hang_idx, .done(ack0), .err(err0), .rdata(rdd0));

  swreg_bridge #(.VARIANT(1), .TIMEOUT_CYCLES(TMO)) u1 (
    .clk, .rst_n, .req_start(start1), .req_write(wr), .req_addr(addr), .req_wdata(wdat),
    .req_done(done1), .req_status(st1), .req_rdata(rd1),
    .cmd_valid(v1), .cmd_write(cw1), .cmd_phy(ph1), .cmd_reg(rg1), .cmd_wdata(cd1),
    .cmd_done(ack1), .cmd_err(err1), .cmd_rdata(rdd1));
  sim_resp r1 (.clk, .clr, .cmd_valid(v1), .cmd_write(cw1), .phy(ph1), .rg(rg1), .wd(cd1),
    .lat, .fail_idx, .hang_idx, .done(ack1), .err(err1), .rdata(rdd1));

  int checks = 0, failures = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] fval(input logic [4:0] p, input logic [4:0] r);
    return {p, 1'b0, r, 5'h0} ^ 16'h5A5A;
  endfunction

  function automatic logic [4:0] lg_phy(input int s, input int i);
    return s ? r1.lphy[i] : r0.lphy[i];
  endfunction
  function automatic logic [4:0] lg_reg(input int s, input int i);
    return s ? r1.lreg[i] : r0.lreg[i];
  endfunction
  function automatic logic lg_w(input int s, input int i);
    return s ? r1.lw[i] : r0.lw[i];
  endfunction
  function automatic logic [15:0] lg_d(input int s, input int i);
    return s ? r1.ld[i] : r0.ld[i];
  endfunction

  task automatic run(input int s, input bit w, input logic [9:0] a, input logic [31:0] d,
                     input int l, input int fi, input int hi, input bit extra);
    bit seen = 0, lo_first, hfirst;
    logic [1:0] stat = '0, exp_stat;
    logic [31:0] rres = '0;
    int ndone = 0, nexp;
    logic [4:0] ephy, rbase;
    @(negedge clk);
    lat = l; fail_idx = fi; hang_idx = hi; clr = 1;
    @(negedge clk);
    clr = 0; wr = w; addr = a; wdat = d;
    if (s) start1 = 1; else start0 = 1;
    @(negedge clk);
    start0 = 0; start1 = 0;
    for (int c = 0; c < 120; c++) begin
      if (extra && c == 2) begin
        addr = a ^ 10'h3FF; wdat = ~d; wr = !w;
        if (s) start1 = 1; else start0 = 1;
      end else begin
        start0 = 0; start1 = 0;
      end
      @(negedge clk);
      if (s ? done1 : done0) begin
        ndone++;
        if (!seen) begin
          stat = s ? st1 : st0;
          rres = s ? rd1 : rd0;
          seen = 1;
          chk(s ? ack1 === 1'b0 : ack0 === 1'b0, "R9 done one cycle after last ack", 0, 0);
        end
      end
    end
    start0 = 0; start1 = 0;
    chk(seen, "R9 done seen", {31'b0, seen}, 1);
    chk(ndone == 1, "R9/R10 exactly one done pulse", ndone, 1);
    exp_stat = (fi >= 0) ? 2'b01 : (hi >= 0) ? 2'b10 : 2'b00;
    nexp = (fi >= 0) ? fi + 1 : (hi >= 0) ? hi + 1 : 3;
    chk(stat == exp_stat, (fi >= 0) ? "R7 error status" : (hi >= 0) ? "R8 timeout status" : "R9 ok status",
        stat, exp_stat);
    chk((s ? r1.n : r0.n) == nexp, "R7/R8/R10 transaction count", s ? r1.n : r0.n, nexp);
    chk(lg_phy(s,0) == (s ? 5'h18 : 5'h1F) && lg_reg(s,0) == (s ? 5'h00 : 5'h10)
        && lg_w(s,0) && lg_d(s,0) == {15'b0, a[9]},
        "R1 page write", {lg_w(s,0), lg_phy(s,0), lg_reg(s,0), lg_d(s,0)},
        {1'b1, s ? 5'h18 : 5'h1F, s ? 5'h00 : 5'h10, 15'b0, a[9]});
    if (nexp == 3) begin
      lo_first = !w || (s == 0 && a == 10'h098);
      ephy = {2'b10, a[8:6]};
      rbase = {a[5:2], 1'b0};
      for (int i = 1; i < 3; i++) begin
        hfirst = (i == 1) ? !lo_first : lo_first;
        chk(lg_phy(s,i) == ephy, "R2 half phy", lg_phy(s,i), ephy);
        chk(lg_reg(s,i) == (rbase | 5'(hfirst)), (w && a == 10'h098) ? "R6 half order" : "R3 half reg",
            lg_reg(s,i), rbase | 5'(hfirst));
        chk(lg_w(s,i) == w, "R5 half direction", lg_w(s,i), w);
        if (w) chk(lg_d(s,i) == (hfirst ? d[31:16] : d[15:0]), "R5 half data",
                   lg_d(s,i), hfirst ? d[31:16] : d[15:0]);
      end
      if (!w) chk(rres == {fval(ephy, rbase | 5'd1), fval(ephy, rbase)}, "R4 read result",
                  rres, {fval(ephy, rbase | 5'd1), fval(ephy, rbase)});
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    seed = 32'd7;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!done0 && !v0 && st0 == 0 && rd0 == 0, "R11 reset state",
        {done0, v0, st0, rd0[27:0]}, 0);
    run(0, 1'b0, 10'h10C, 32'h0, 0, -1, -1, 0);
    run(0, 1'b1, 10'h098, 32'hDEAD_BEEF, 1, -1, -1, 0);  // R6
    run(0, 1'b0, 10'h098, 32'h0, 0, -1, -1, 0);          // R6 read keeps order
    run(0, 1'b1, 10'h040, 32'h1234_5678, 2, -1, -1, 0);  // R5
    run(0, 1'b1, 10'h3FF, 32'hA5A5_0F0F, 0, -1, -1, 0);
    run(1, 1'b1, 10'h098, 32'hCAFE_F00D, 0, -1, -1, 0);  // R1 R6 variant 1
    run(1, 1'b0, 10'h2C4, 32'h0, 1, -1, -1, 0);
    for (int k = 0; k < 3; k++) run(0, 1'b1, 10'h15A, 32'h0BAD_CAFE, 1, k, -1, 0); // R7
    run(0, 1'b0, 10'h200, 32'h0, 0, -1, 0, 0);           // R8
    run(0, 1'b1, 10'h0F3, 32'h7777_8888, 0, -1, 2, 0);   // R8
    run(0, 1'b1, 10'h0C8, 32'h1111_2222, 3, -1, -1, 1);  // R10
    run(0, 1'b0, 10'h1E4, 32'h0, 3, -1, -1, 1);          // R10
    for (int k = 0; k < 30; k++)
      run($urandom_range(0, 1), 1'($urandom_range(0, 1)), 10'($urandom_range(0, 1023)),
          $urandom, $urandom_range(0, 3), -1, -1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule